// File: doc/BRIEF.md
# Serial Line Scrambler and NRZI Codec

This block turns a stream of 10-bit parallel words into a single scrambled, transition-coded serial line, and recovers the words from such a line on the receive side. The transmitter loads a word when a load strobe is seen and shifts it out least significant bit first, one bit per clock, so the serial clock runs at ten times the word rate. Each serial bit passes through a self-synchronising scrambler built on the polynomial x^9 + x^4 + 1 and then through an x + 1 stage that codes ones as line transitions.

The receiver removes the transition coding, descrambles with the same taps applied to the received bits, and presents the recovered bit stream. Because only transitions carry data and the descrambler history is filled from the line itself, the receiver needs no seed and does not care about line polarity. An aligner state machine watches the recovered stream for a synchronisation run (one all-ones word followed by two all-zeros words) and from then on delivers complete parallel words with a one-cycle valid strobe.

The aligner has two states. SEARCH is entered at reset; the transition SEARCH to LOCKED (named "acquire") fires when the sync run is seen. In LOCKED the transition LOCKED to LOCKED (named "realign") restarts the word counter whenever the sync run is seen again, at whatever bit phase it arrives. There is no path back to SEARCH except reset.

Top module: `serial_link_codec`

## Requirements
- R1: While rst_n is low, line_out, rx_bit, rx_word_valid and rx_locked are all 0.
- R2: A clock edge with word_load high captures tx_word; its bits are sent least significant first, bit k in the k-th clock after the capture; with no further load the sender shifts out 0 bits.
- R3: The scrambled bit equals the data bit XOR the scrambled bits produced 4 and 9 clocks earlier.
- R4: line_out toggles on the clock edge after a scrambled 1 and holds after a scrambled 0.
- R5: With line_in tied to line_out, bit k of a word captured at edge n appears on rx_bit after edge n+3+k, for every word value.
- R6: Inverting line_in, either constantly or by a flip in mid-stream, leaves rx_bit correct except for at most the 10 recovered bits after the flip.
- R7: The aligner is in SEARCH after reset (rx_locked 0); when the third word of the sync run 3FF, 000, 000 (ten ones then twenty zeros in line order) is captured at edge n, rx_locked is still 0 after edge n+12 and is 1 after edge n+13.
- R8: In LOCKED, each group of ten recovered bits after the sync run is delivered on rx_word (first recovered bit in bit 0) with rx_word_valid high for exactly one cycle, and no word is lost.
- R9: rx_locked stays 1 until reset; a sync run arriving at a different bit phase moves the word boundary to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_load | input | 1 | Capture strobe for tx_word |
| tx_word | input | 10 | Parallel word to transmit |
| line_out | output | 1 | Transition-coded serial line |
| line_in | input | 1 | Received serial line |
| rx_bit | output | 1 | Recovered, descrambled bit |
| rx_word | output | 10 | Recovered parallel word |
| rx_word_valid | output | 1 | One-cycle strobe for rx_word |
| rx_locked | output | 1 | Word boundary acquired |

## Verification
A wrong bit in either scrambler history shows on rx_bit as a short burst of errors at offsets of 0, 4 and 9 bits from the fault and then disappears, so the bit-exact round-trip comparison sees it within ten clocks. A wrong transition-coder level only matters if the decoder misreads a transition, which shows up at once in the same comparison. A slipped aligner counter or a missed sync detection shows as rotated words or a missing strobe at the next rx_word_valid, at most ten clocks later, and a wrong lock timing shows as rx_locked rising one edge early or late.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int WORD_W   = 10;
    localparam int TAP_NEAR = 4;
    localparam int TAP_FAR  = 9;

    typedef enum logic [0:0] {
        AL_SEARCH = 1'b0,
        AL_LOCKED = 1'b1
    } align_state_t;
endpackage

// File: rtl/slc_serializer.sv
module slc_serializer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         ser_bit
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= word;
        else
            shreg <= {1'b0, shreg[W-1:1]};
    end

    assign ser_bit = shreg[0];
endmodule

// File: rtl/slc_scrambler.sv
module slc_scrambler #(
    parameter int NEAR       = 4,
    parameter int FAR        = 9,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [FAR-1:0] hist;
    logic           fb;

    assign dout = din ^ hist[NEAR-1] ^ hist[FAR-1];

    generate
        if (DESCRAMBLE) begin : g_feed_line
            assign fb = din;
        end else begin : g_feed_self
            assign fb = dout;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= '0;
        else
            hist <= {hist[FAR-2:0], fb};
    end
endmodule

// File: rtl/slc_nrzi.sv
module slc_nrzi #(
    parameter bit DECODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (!DECODE) begin : g_enc
            logic lvl;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    lvl <= 1'b0;
                else
                    lvl <= lvl ^ din;
            end
            assign dout = lvl;
        end else begin : g_dec
            logic cur, prv;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur <= 1'b0;
                    prv <= 1'b0;
                end else begin
                    cur <= din;
                    prv <= cur;
                end
            end
            assign dout = cur ^ prv;
        end
    endgenerate
endmodule

// File: rtl/slc_aligner.sv
module slc_aligner
    import slc_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] word_out,
    output logic         word_valid,
    output logic         locked
);
    localparam int PW  = 3 * W;
    localparam int CW  = $clog2(W);
    localparam logic [PW-1:0] SYNC_PAT = {{(2*W){1'b0}}, {W{1'b1}}};
    localparam logic [CW-1:0] LAST_POS = CW'(W - 1);

    align_state_t  state, state_nx;
    logic [PW-1:0] win, win_nx;
    logic [W-1:0]  assy;
    logic [CW-1:0] pos;
    logic          hit;

    // oldest bit sits in win[0]; the sync run starts with ten ones
    assign win_nx = {bit_in, win[PW-1:1]};
    assign hit    = (win_nx == SYNC_PAT);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            AL_SEARCH: if (hit) state_nx = AL_LOCKED;   // acquire
            AL_LOCKED: state_nx = AL_LOCKED;            // realign handled by counter
            default:   state_nx = AL_SEARCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= AL_SEARCH;
        else
            state <= state_nx;
    end

    // data path and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win        <= '0;
            assy       <= '0;
            pos        <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            win  <= win_nx;
            assy <= {bit_in, assy[W-1:1]};
            if (hit || pos == LAST_POS)
                pos <= '0;
            else
                pos <= pos + 1'b1;
            if (state == AL_LOCKED && pos == LAST_POS) begin
                word_out   <= {bit_in, assy[W-1:1]};
                word_valid <= 1'b1;
            end else begin
                word_valid <= 1'b0;
            end
        end
    end

    assign locked = (state == AL_LOCKED);
endmodule

// File: rtl/serial_link_codec.sv
module serial_link_codec
    import slc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_load,
    input  logic [WORD_W-1:0] tx_word,
    output logic              line_out,
    input  logic              line_in,
    output logic              rx_bit,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_valid,
    output logic              rx_locked
);
    logic ser_bit;
    logic scr_bit;
    logic nrz_bit;
    logic desc_bit;
    logic rx_bit_q;

    slc_serializer #(.W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(word_load), .word(tx_word), .ser_bit(ser_bit)
    );

    slc_scrambler #(.NEAR(TAP_NEAR), .FAR(TAP_FAR), .DESCRAMBLE(1'b0)) u_scr (
        .clk(clk), .rst_n(rst_n), .din(ser_bit), .dout(scr_bit)
    );

    slc_nrzi #(.DECODE(1'b0)) u_enc (
        .clk(clk), .rst_n(rst_n), .din(scr_bit), .dout(line_out)
    );

    slc_nrzi #(.DECODE(1'b1)) u_dec (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(nrz_bit)
    );

    slc_scrambler #(.NEAR(TAP_NEAR), .FAR(TAP_FAR), .DESCRAMBLE(1'b1)) u_dscr (
        .clk(clk), .rst_n(rst_n), .din(nrz_bit), .dout(desc_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_bit_q <= 1'b0;
        else
            rx_bit_q <= desc_bit;
    end

    assign rx_bit = rx_bit_q;

    slc_aligner #(.W(WORD_W)) u_align (
        .clk(clk), .rst_n(rst_n), .bit_in(rx_bit_q),
        .word_out(rx_word), .word_valid(rx_word_valid), .locked(rx_locked)
    );
endmodule

// File: rtl/slc_checker.sv
module slc_checker
    import slc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic ser_bit,
    input logic scr_bit,
    input logic line_out,
    input logic nrz_bit,
    input logic desc_bit,
    input logic rx_bit,
    input logic rx_word_valid,
    input logic rx_locked
);
    logic [3:0] since_rst;
    logic       hist_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 4'hF)
            since_rst <= since_rst + 1'b1;
    end

    assign hist_ok = (since_rst > 4'(TAP_FAR));

    // R3: scrambler taps at 4 and 9 clocks back
    assert_scramble_taps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (scr_bit == (ser_bit ^ $past(scr_bit, TAP_NEAR) ^ $past(scr_bit, TAP_FAR))));

    // R4: line toggles exactly on a scrambled one
    assert_line_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 4'h0) |=> (line_out == ($past(line_out) ^ $past(scr_bit))));

    // R5: descrambler uses the received scrambled bits
    assert_descramble_taps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (desc_bit == (nrz_bit ^ $past(nrz_bit, TAP_NEAR) ^ $past(nrz_bit, TAP_FAR))));

    // R5: recovered bit is the descrambler result one clock later
    assert_rx_bit_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 4'h0) |=> (rx_bit == $past(desc_bit)));

    // R8: word strobe lasts one cycle and only while locked
    assert_word_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid |=> !rx_word_valid);
    assert_valid_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid |-> rx_locked);

    // R9: lock never drops without reset
    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_locked |=> rx_locked);
endmodule

bind serial_link_codec slc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .scr_bit(scr_bit),
    .line_out(line_out), .nrz_bit(nrz_bit), .desc_bit(desc_bit),
    .rx_bit(rx_bit), .rx_word_valid(rx_word_valid), .rx_locked(rx_locked)
);

// File: tb/serial_link_codec_test.sv
module serial_link_codec_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         word_load;
    logic [W-1:0] tx_word;
    logic         line_out;
    logic         inv;
    wire          line_in = line_out ^ inv;
    logic         rx_bit;
    logic [W-1:0] rx_word;
    logic         rx_word_valid;
    logic         rx_locked;

    serial_link_codec uut (
        .clk(clk), .rst_n(rst_n), .word_load(word_load), .tx_word(tx_word),
        .line_out(line_out), .line_in(line_in), .rx_bit(rx_bit),
        .rx_word(rx_word), .rx_word_valid(rx_word_valid), .rx_locked(rx_locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ec = 0;              // index of the next rising edge
    bit txbit [0:32767];     // expected serial data bit after each edge
    int exp_q [0:2047];
    int qn = 0;
    int wp = 0;
    bit bchk = 0;
    bit wchk = 0;
    bit lock_watch = 0;
    int bit_from = 1 << 30;
    int mask_until = 0;
    int sync_edge = 1 << 29;
    bit done = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // record the serial data bits each captured word will produce (R2)
    always @(posedge clk) begin
        if (rst_n && word_load)
            for (int k = 0; k < W; k++) txbit[ec + k] = tx_word[k];
        ec++;
    end

    // checks of the receive side, away from the active edge
    always @(negedge clk) begin
        int m;
        m = ec - 1;
        if (bchk && m >= bit_from && m >= mask_until)
            check("R5", $sformatf("rx_bit after edge %0d", m), 32'(rx_bit), 32'(txbit[m-3]));
        if (lock_watch && m == sync_edge + 12)
            check("R7", "rx_locked one edge before lock", 32'(rx_locked), 32'd0);
        if (lock_watch && m == sync_edge + 13)
            check("R7", "rx_locked at lock edge", 32'(rx_locked), 32'd1);
        if (rx_word_valid && wchk && m >= sync_edge + 14 && wp < qn) begin
            check("R8", $sformatf("rx_word %0d", wp), 32'(rx_word), 32'(exp_q[wp]));
            wp++;
        end
    end

    task automatic send_word(input logic [W-1:0] w, output int e);
        word_load = 1'b1;
        tx_word   = w;
        e         = ec;
        @(negedge clk);
        word_load = 1'b0;
        repeat (W - 1) @(negedge clk);
    endtask

    task automatic send_sync();
        int e;
        send_word(10'h3FF, e);
        send_word(10'h000, e);
        sync_edge = ec;
        send_word(10'h000, e);
    endtask

    task automatic flip_line();
        inv = ~inv;
        mask_until = ec + 11;   // R6: at most ten corrupted recovered bits
    endtask

    initial begin
        int e;
        rst_n = 1'b0;
        word_load = 1'b0;
        tx_word = '0;
        inv = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1", "line_out in reset", 32'(line_out), 32'd0);
        check("R1", "rx_bit in reset", 32'(rx_bit), 32'd0);
        check("R1", "rx_word_valid in reset", 32'(rx_word_valid), 32'd0);
        check("R1", "rx_locked in reset", 32'(rx_locked), 32'd0);
        rst_n = 1'b1;
        bit_from = ec + 12;
        bchk = 1'b1;
        repeat (20) @(negedge clk);
        check("R7", "rx_locked before sync", 32'(rx_locked), 32'd0);

        // phase 1: acquire and sweep every word value (R2, R3, R4, R5, R8)
        lock_watch = 1'b1;
        send_sync();
        wchk = 1'b1;
        for (int i = 1; i < 1024; i++) begin
            exp_q[qn] = i;
            qn++;
            send_word(W'(i), e);
        end
        lock_watch = 1'b0;
        repeat (30) @(negedge clk);
        wchk = 1'b0;
        check("R8", "words delivered in sweep", 32'(wp), 32'(qn));

        // phase 2: polarity flips in mid-stream (R6)
        for (int f = 0; f < 3; f++) begin
            flip_line();
            for (int i = 0; i < 6; i++)
                send_word(W'((i * 97 + f * 31 + 5) % 1023), e);
        end
        repeat (12) @(negedge clk);

        // phase 3: sync at a different bit phase while locked (R9)
        repeat (3) @(negedge clk);
        qn = 0;
        wp = 0;
        send_sync();
        wchk = 1'b1;
        for (int i = 0; i < 40; i++) begin
            exp_q[qn] = i * 7 + 1;
            qn++;
            send_word(W'(i * 7 + 1), e);
        end
        repeat (30) @(negedge clk);
        wchk = 1'b0;
        check("R9", "words delivered after realign", 32'(wp), 32'(qn));
        check("R9", "rx_locked held", 32'(rx_locked), 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule